// File: doc/BRIEF.md
# Shared-Counter 10-bit PWM Bank

A bank of PWM output channels driven by one free-running 10-bit counter. Every channel has the same period of 1024 enabled clock cycles. Each channel compares the counter, widened to 11 bits with a zero on top, against its own 11-bit active compare value. The output is low while the counter is below that value and high once it is equal or above. Because the compare value is one bit wider than the counter, a channel can hold a steady low for the whole period.

Software-side logic can load a channel's shadow compare register at any cycle. The shadow is copied into the active compare register only on the clock edge where the counter rolls from its top value back to zero. A duty-cycle change therefore always takes effect at the start of a period, so no period is cut short or stretched. A per-channel 2-bit mode field enables each output. A one-cycle wrap pulse marks the last enabled cycle of every period.

Top module: `pwm10_bank`

## Requirements
- R1: A channel's output follows the compare only while its 2-bit mode field is binary 11. Any other mode value forces that output to 0.
- R2: The counter advances by one on each clock edge with `cnt_en` high and rolls from 1023 to 0. `wrap` is high exactly in the cycles where the count is 1023 and `cnt_en` is high.
- R3: With mode 11, a channel's output is 1 when {0,count} is greater than or equal to its 11-bit active compare value, and 0 otherwise.
- R4: Raising `shd_we[i]` loads bits [11*i+10 : 11*i] of `shd_wdata` into shadow register i at that edge. The active value does not change, so the output keeps its current behaviour until the next wrap.
- R5: On the edge that ends a wrap cycle, every active compare register takes the value its shadow held before that edge. A shadow write on the same edge is therefore applied one period later.
- R6: An active compare value of 0x000 gives a constant high output for the whole period.
- R7: An active compare value of 0x7FF gives a constant low output for the whole period.
- R8: While `cnt_en` is low, the counter holds, no reload takes place even at count 1023, and each output stays at its compare result for the held count.
- R9: Reset (`rst_n` low, asynchronous) clears the counter, the shadow registers and the active registers to 0. Right after reset, a channel in mode 11 drives 1 and `wrap` is 0.
- R10: Over a full enabled period with active value A, a mode-11 output is high for 1024−A cycles when A ≤ 1024, and for 0 cycles when A is above 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| mode_sel | input | 2*NCH | 2-bit mode per channel; 11 enables PWM |
| shd_we | input | NCH | Per-channel shadow write strobe |
| shd_wdata | input | 11*NCH | Per-channel 11-bit shadow value |
| pwm_out | output | NCH | PWM output per channel |
| wrap | output | 1 | High in the last enabled cycle of a period |

## Verification
Four channels are set at the same time to 0x000, 0x100, 0x3FF and 0x7FF. This separates the constant-high and constant-low ends from an ordinary duty and from the one-cycle-high edge. Shadow writes land mid-period, on the wrap edge itself, and during enable-low holds at count 1023. These show whether a reload happens early, late, or while stalled. Values of 0x400 and 1 probe the boundary at the counter width, and mixed mode fields show that non-11 modes idle the output. A behavioural model is compared with every output on every cycle, and high cycles are counted per period against 1024−A.

// File: rtl/pwm10_bank.sv
module pwm10_bank #(
  parameter int NCH   = 4,
  parameter int CNT_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cnt_en,
  input  logic [2*NCH-1:0]         mode_sel,
  input  logic [NCH-1:0]           shd_we,
  input  logic [NCH*(CNT_W+1)-1:0] shd_wdata,
  output logic [NCH-1:0]           pwm_out,
  output logic                     wrap
);
  localparam int CMP_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [1:0] PWM_MODE = 2'b11;

  logic [CNT_W-1:0]     cnt;
  logic [NCH*CMP_W-1:0] act_flat;
  logic [NCH*CMP_W-1:0] shd_flat;

  assign wrap = cnt_en && (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CMP_W-1:0] shd_q, act_q;
    logic [1:0]       mode_i;

    assign mode_i = mode_sel[2*i +: 2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= '0;
        act_q <= '0;
      end else begin
        if (shd_we[i]) shd_q <= shd_wdata[i*CMP_W +: CMP_W];
        if (wrap)      act_q <= shd_q;
      end
    end

    assign pwm_out[i] = (mode_i == PWM_MODE) && ({1'b0, cnt} >= act_q);
    assign act_flat[i*CMP_W +: CMP_W] = act_q;
    assign shd_flat[i*CMP_W +: CMP_W] = shd_q;
  end

endmodule

module pwm10_bank_chk #(
  parameter int NCH   = 4,
  parameter int CNT_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cnt_en,
  input logic [2*NCH-1:0]         mode_sel,
  input logic [NCH-1:0]           pwm_out,
  input logic                     wrap,
  input logic [CNT_W-1:0]         cnt,
  input logic [NCH*(CNT_W+1)-1:0] act_flat
);
  localparam int CMP_W = CNT_W + 1;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cnt_en) && !$past(wrap)) |-> (cnt == $past(cnt) + 1'b1));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(cnt_en)) |-> ($stable(cnt) && $stable(act_flat)));

  // R5
  reload_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(wrap)) |-> $stable(act_flat));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R1
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[2*i +: 2] != 2'b11) |-> !pwm_out[i]);

    // R7
    const_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_flat[i*CMP_W +: CMP_W] == {CMP_W{1'b1}}) |-> !pwm_out[i]);

    // R6
    const_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_flat[i*CMP_W +: CMP_W] == '0) && (mode_sel[2*i +: 2] == 2'b11)) |-> pwm_out[i]);
  end
endmodule

bind pwm10_bank pwm10_bank_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_sel(mode_sel),
  .pwm_out(pwm_out), .wrap(wrap), .cnt(cnt), .act_flat(act_flat)
);

// File: tb/pwm10_bank_test.sv
module pwm10_bank_test;
  localparam int NCH = 4;
  localparam int W   = 11;
  localparam int TOP = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic [2*NCH-1:0] mode_sel = '1;
  logic [NCH-1:0] shd_we = '0;
  logic [NCH*W-1:0] shd_wdata = '0;
  logic [NCH-1:0] pwm_out;
  logic wrap;

  always #2.5 clk = ~clk;

  pwm10_bank #(.NCH(NCH), .CNT_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_sel(mode_sel),
    .shd_we(shd_we), .shd_wdata(shd_wdata), .pwm_out(pwm_out), .wrap(wrap)
  );

  int nvec = 0, nfail = 0;
  bit done = 0;
  int m_cnt;
  int m_act[NCH];
  int m_shd[NCH];
  int hi_n[NCH];
  bit per_ok[NCH];
  bit started;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d (count %0d, t=%0t)", tag, act, exp, m_cnt, $time);
    end
  endtask

  function automatic int exp_pwm(int i);
    return (mode_sel[2*i +: 2] == 2'b11 && m_cnt >= m_act[i]) ? 1 : 0;
  endfunction

  task automatic tick();
    bit wr;
    #1;
    wr = cnt_en && (m_cnt == TOP);
    chk("R2 wrap", int'(wrap), int'(wr));
    for (int i = 0; i < NCH; i++) begin
      // R1 R3: per-cycle compare
      chk($sformatf("R3 ch%0d", i), int'(pwm_out[i]), exp_pwm(i));
      if (cnt_en) begin
        if (mode_sel[2*i +: 2] != 2'b11) per_ok[i] = 0;
        hi_n[i] += int'(pwm_out[i]);
      end
    end
    if (wr) begin
      for (int i = 0; i < NCH; i++) begin
        if (started && per_ok[i])
          // R10: high cycles per full period
          chk($sformatf("R10 ch%0d highs", i), hi_n[i],
              (m_act[i] <= 1024) ? 1024 - m_act[i] : 0);
        hi_n[i] = 0;
        per_ok[i] = 1;
      end
      started = 1;
    end
    @(posedge clk);
    if (cnt_en) begin
      if (m_cnt == TOP) begin
        m_cnt = 0;
        for (int i = 0; i < NCH; i++) m_act[i] = m_shd[i];
      end else m_cnt++;
    end
    for (int i = 0; i < NCH; i++)
      if (shd_we[i]) m_shd[i] = int'(shd_wdata[i*W +: W]);
    @(negedge clk);
    shd_we = '0;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic run_to(input int c);
    while (m_cnt != c) tick();
  endtask

  task automatic wr_shd(input int i, input int v);
    shd_we[i] = 1'b1;
    shd_wdata[i*W +: W] = W'(v);
  endtask

  initial begin
    m_cnt = 0;
    started = 0;
    for (int i = 0; i < NCH; i++) begin
      m_act[i] = 0; m_shd[i] = 0; hi_n[i] = 0; per_ok[i] = 1;
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 pwm after reset", int'(pwm_out), 15);
    chk("R9 wrap after reset", int'(wrap), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cnt_en = 1'b1;

    // R4 R6 R7: distinct duties, applied after next wrap
    wr_shd(0, 11'h000); wr_shd(1, 11'h100); wr_shd(2, 11'h3FF); wr_shd(3, 11'h7FF);
    tick();
    run_to(TOP); tick();
    run(2 * 1024);

    // R4 R5: mid-period writes, boundary values
    run_to(500);
    wr_shd(0, 11'h200); wr_shd(1, 11'h400); wr_shd(2, 11'h001); wr_shd(3, 11'h000);
    tick();
    run_to(0); run(1024);

    // R8: hold mid-period, then at count 1023 with a pending write
    run_to(300);
    cnt_en = 1'b0; run(40); cnt_en = 1'b1;
    run_to(TOP);
    cnt_en = 1'b0;
    wr_shd(0, 11'h7FF); wr_shd(2, 11'h3FE);
    run(20);
    cnt_en = 1'b1;
    run(1030);

    // R5: shadow write on the wrap edge itself
    run_to(TOP);
    wr_shd(1, 11'h055); wr_shd(3, 11'h080);
    tick();
    run(1030);

    // R1: mixed modes
    mode_sel = 8'b11_10_01_00;
    run(1100);
    mode_sel = '1;
    run(1100);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule